// File: doc/BRIEF.md
# Output Compare Channel

This block is one output compare channel. It watches a 16-bit timer count and compares it with two stored values, a primary and a secondary compare value. On each match it sets or clears an output latch, and the latch drives a single pin. The channel can take its count and period strobe from either of two external timebases. A select input picks which timebase is used.

A 3-bit mode register sets the behaviour. Writing this register also re-arms the channel:

| Code | Mode |
|------|------|
| 000 | Disabled |
| 001 | Single match: drive high |
| 010 | Single match: drive low |
| 011 | Single match: toggle |
| 100 | Two-compare single pulse |
| 101 | Two-compare continuous pulses |
| 110 | PWM |
| 111 | PWM with fault shutdown |

In the PWM modes the secondary value is a duty setting. It is copied into an internal duty register only at a period match, so a new duty value never cuts short the period in progress. An active-low fault pin can shut the output down in mode 111. The shutdown stays latched until software writes the mode register again.

Top module: `cmp_out_channel`

## Requirements
- R1: During and after reset, and before any mode write, `pin_out`, `pin_oe`, `irq_flag` and `fault_flag` are all 0.
- R2: In mode 3'b000, `pin_out` and `pin_oe` stay 0 and `irq_flag` stays 0, whatever the timer counts are.
- R3: With `tb_sel`=0 the channel uses `tmr_a` and `per_a`. With `tb_sel`=1 it uses `tmr_b` and `per_b`. The unselected count and strobe have no effect.
- R4: In modes 3'b001, 3'b010 and 3'b011, a clock edge at which the count equals the primary value does the following from the next cycle: it sets the pin high (001), clears it low (010) or inverts it (011). It also raises `irq_flag` for that one cycle.
- R5: A mode write takes effect at the next cycle. The pin is set to its starting level, which is 1 for 3'b010 and 0 for every other mode. The write also re-arms single-pulse mode, clears `fault_flag` and loads the duty register from the secondary value.
- R6: In mode 3'b100 the pin rises after the edge at which the count equals the primary value. It falls after the edge at which the count equals the secondary value, and `irq_flag` pulses for one cycle at that fall. After this the pin stays low until the mode is written again.
- R7: Mode 3'b101 produces the same rise and fall as R6, but repeats on every timer cycle, with an `irq_flag` pulse at each fall.
- R8: In modes 3'b110 and 3'b111, a period strobe sets the pin high and copies the secondary value into the duty register. A later edge at which the count equals the duty register clears the pin and pulses `irq_flag`.
- R9: A secondary value written in the middle of a PWM period does not change the fall point of that period. It takes effect from the next period match.
- R10: Outside mode 3'b111, `fault_n` has no effect on the pin, and `fault_flag` stays 0.
- R11: In mode 3'b111, an edge with `fault_n` low sets `fault_flag` and forces `pin_out` and `pin_oe` to 0 from the next cycle. This state stays after `fault_n` returns high, until the next mode write, and it suppresses `irq_flag`.
- R12: `pin_oe` is 1 whenever the mode is non-zero and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_a | input | 16 | Count from timebase A |
| tmr_b | input | 16 | Count from timebase B |
| per_a | input | 1 | Period-match strobe from timebase A |
| per_b | input | 1 | Period-match strobe from timebase B |
| tb_sel | input | 1 | Timebase select, 0 = A, 1 = B |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 3 | New mode code |
| pri_we | input | 1 | Primary compare write strobe |
| pri_wdata | input | 16 | New primary compare value |
| sec_we | input | 1 | Secondary compare write strobe |
| sec_wdata | input | 16 | New secondary compare value |
| fault_n | input | 1 | Active-low fault pin |
| pin_out | output | 1 | Output pin level |
| pin_oe | output | 1 | Output enable |
| irq_flag | output | 1 | One-cycle compare event strobe |
| fault_flag | output | 1 | Latched fault shutdown status |

## Verification
The properties assume that a fault shutdown can only start from mode 111 with `fault_n` low, and that no mode write lands in the same cycle as a fault. The stimulus writes the compare values only while the channel is disabled. The one exception is the mid-period duty change, which is never placed on a period-strobe cycle. During write cycles the stimulus holds the counts at a value that no compare register ever holds. Each timebase count sweeps 0 to 9, with its strobe at 9. The count on the unselected timebase is skewed so that a wrong selection would produce a different waveform.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

   typedef enum logic [2:0] {
      MD_OFF    = 3'b000,
      MD_SET    = 3'b001,
      MD_CLR    = 3'b010,
      MD_TGL    = 3'b011,
      MD_PULSE1 = 3'b100,
      MD_PULSEN = 3'b101,
      MD_PWM    = 3'b110,
      MD_PWMF   = 3'b111
   } oc_mode_e;

   localparam int unsigned MODE_W = 3;
   localparam int unsigned NUM_REF = 3;

   localparam int unsigned REF_PRI  = 0;
   localparam int unsigned REF_SEC  = 1;
   localparam int unsigned REF_DUTY = 2;

   function automatic logic start_level(input oc_mode_e m);
      return (m == MD_CLR);
   endfunction

   function automatic logic is_pwm(input oc_mode_e m);
      return (m == MD_PWM) || (m == MD_PWMF);
   endfunction

endpackage

// File: rtl/cmp_out_tsel.sv
module cmp_out_tsel #(
   parameter int unsigned TW = 16
) (
   input  logic          tb_sel,
   input  logic [TW-1:0] tmr_a,
   input  logic [TW-1:0] tmr_b,
   input  logic          per_a,
   input  logic          per_b,
   output logic [TW-1:0] tmr,
   output logic          per
);

   always_comb begin
      if (tb_sel) begin
         tmr = tmr_b;
         per = per_b;
      end else begin
         tmr = tmr_a;
         per = per_a;
      end
   end

endmodule

// File: rtl/cmp_out_regs.sv
module cmp_out_regs
   import cmp_out_pkg::*;
#(
   parameter int unsigned TW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pri_we,
   input  logic [TW-1:0]     pri_wdata,
   input  logic              sec_we,
   input  logic [TW-1:0]     sec_wdata,
   input  logic              duty_ld,
   input  logic [TW-1:0]     tmr,
   output logic [NUM_REF-1:0] eq
);

   logic [TW-1:0] pri_q;
   logic [TW-1:0] sec_q;
   logic [TW-1:0] duty_q;
   logic [TW-1:0] refs [NUM_REF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pri_q  <= '0;
         sec_q  <= '0;
         duty_q <= '0;
      end else begin
         if (pri_we)  pri_q  <= pri_wdata;
         if (sec_we)  sec_q  <= sec_wdata;
         if (duty_ld) duty_q <= sec_q;
      end
   end

   assign refs[REF_PRI]  = pri_q;
   assign refs[REF_SEC]  = sec_q;
   assign refs[REF_DUTY] = duty_q;

   for (genvar g = 0; g < NUM_REF; g++) begin : g_cmp
      assign eq[g] = (tmr == refs[g]);
   end

endmodule

// File: rtl/cmp_out_logic.sv
module cmp_out_logic
   import cmp_out_pkg::*;
#(
   parameter bit FAULT_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mode_we,
   input  logic [MODE_W-1:0]  mode_wdata,
   input  logic               per,
   input  logic [NUM_REF-1:0] eq,
   input  logic               fault_n,
   output oc_mode_e           mode_q,
   output logic               out_q,
   output logic               fault_q,
   output logic               irq_q,
   output logic               duty_ld
);

   logic     done_q;
   logic     eq_pri, eq_sec, eq_duty;
   logic     flt_block;
   oc_mode_e mode_new;

   assign eq_pri   = eq[REF_PRI];
   assign eq_sec   = eq[REF_SEC];
   assign eq_duty  = eq[REF_DUTY];
   assign mode_new = oc_mode_e'(mode_wdata);
   assign duty_ld  = mode_we || (is_pwm(mode_q) && per);

   if (FAULT_EN) begin : g_fault
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            fault_q <= 1'b0;
         else if (mode_we)
            fault_q <= 1'b0;
         else if (mode_q == MD_PWMF && !fault_n)
            fault_q <= 1'b1;
      end
      assign flt_block = (mode_q == MD_PWMF) && (fault_q || !fault_n);
   end else begin : g_nofault
      assign fault_q   = 1'b0;
      assign flt_block = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MD_OFF;
         out_q  <= 1'b0;
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (mode_we) begin
         mode_q <= mode_new;
         out_q  <= start_level(mode_new);
         done_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         unique case (mode_q)
            MD_OFF: out_q <= 1'b0;
            MD_SET: if (eq_pri) begin
               out_q <= 1'b1;
               irq_q <= 1'b1;
            end
            MD_CLR: if (eq_pri) begin
               out_q <= 1'b0;
               irq_q <= 1'b1;
            end
            MD_TGL: if (eq_pri) begin
               out_q <= ~out_q;
               irq_q <= 1'b1;
            end
            MD_PULSE1, MD_PULSEN: begin
               if (!done_q) begin
                  if (out_q && eq_sec) begin
                     out_q  <= 1'b0;
                     irq_q  <= 1'b1;
                     done_q <= (mode_q == MD_PULSE1);
                  end else if (!out_q && eq_pri) begin
                     out_q <= 1'b1;
                  end
               end
            end
            MD_PWM, MD_PWMF: begin
               if (per) begin
                  out_q <= 1'b1;
               end else if (out_q && eq_duty) begin
                  out_q <= 1'b0;
                  irq_q <= !flt_block;
               end
            end
            default: out_q <= 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/cmp_out_channel.sv
module cmp_out_channel
   import cmp_out_pkg::*;
#(
   parameter int unsigned TW       = 16,
   parameter bit          FAULT_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TW-1:0]     tmr_a,
   input  logic [TW-1:0]     tmr_b,
   input  logic              per_a,
   input  logic              per_b,
   input  logic              tb_sel,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   input  logic              pri_we,
   input  logic [TW-1:0]     pri_wdata,
   input  logic              sec_we,
   input  logic [TW-1:0]     sec_wdata,
   input  logic              fault_n,
   output logic              pin_out,
   output logic              pin_oe,
   output logic              irq_flag,
   output logic              fault_flag
);

   if (TW < 4 || TW > 32) begin : g_bad_width
      $error("cmp_out_channel: TW must lie in 4..32");
   end

   logic [TW-1:0]      tmr;
   logic               per;
   logic [NUM_REF-1:0] eq;
   logic               duty_ld;
   oc_mode_e           mode_q;
   logic               out_q;
   logic               fault_q;
   logic               irq_q;

   cmp_out_tsel #(.TW(TW)) u_tsel (
      .tb_sel (tb_sel),
      .tmr_a  (tmr_a),
      .tmr_b  (tmr_b),
      .per_a  (per_a),
      .per_b  (per_b),
      .tmr    (tmr),
      .per    (per)
   );

   cmp_out_regs #(.TW(TW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .pri_we    (pri_we),
      .pri_wdata (pri_wdata),
      .sec_we    (sec_we),
      .sec_wdata (sec_wdata),
      .duty_ld   (duty_ld),
      .tmr       (tmr),
      .eq        (eq)
   );

   cmp_out_logic #(.FAULT_EN(FAULT_EN)) u_logic (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .per        (per),
      .eq         (eq),
      .fault_n    (fault_n),
      .mode_q     (mode_q),
      .out_q      (out_q),
      .fault_q    (fault_q),
      .irq_q      (irq_q),
      .duty_ld    (duty_ld)
   );

   assign pin_oe     = (mode_q != MD_OFF) && !fault_q;
   assign pin_out    = out_q && pin_oe;
   assign irq_flag   = irq_q;
   assign fault_flag = fault_q;

endmodule

// File: rtl/cmp_out_channel_chk.sv
module cmp_out_channel_chk
   import cmp_out_pkg::*;
#(
   parameter bit FAULT_EN = 1'b1
) (
   input logic     clk,
   input logic     rst_n,
   input logic     mode_we,
   input logic     fault_n,
   input oc_mode_e mode_q,
   input logic     pin_out,
   input logic     pin_oe,
   input logic     irq_flag,
   input logic     fault_flag
);

   p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_OFF) |-> (!pin_out && !pin_oe));

   p_wr_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode_we |=> (!fault_flag && !irq_flag));

   p_flt_only_pwmf_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> (mode_q == MD_PWMF));

   p_flt_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (FAULT_EN && mode_q == MD_PWMF && !fault_n && !mode_we) |=> fault_flag);

   p_flt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !mode_we) |=> fault_flag);

   p_flt_shut_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> (!pin_out && !pin_oe && !irq_flag));

   p_pin_gated_r12: assert property (@(posedge clk) disable iff (!rst_n)
      pin_out |-> pin_oe);

endmodule

bind cmp_out_channel cmp_out_channel_chk #(.FAULT_EN(FAULT_EN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode_we    (mode_we),
   .fault_n    (fault_n),
   .mode_q     (mode_q),
   .pin_out    (pin_out),
   .pin_oe     (pin_oe),
   .irq_flag   (irq_flag),
   .fault_flag (fault_flag)
);

// File: tb/cmp_out_channel_tb_top.sv
module cmp_out_channel_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 200000;

   // Mode codes: 000 off, 001 set, 010 clear, 011 toggle,
   // 100 single pulse, 101 continuous pulse, 110 PWM, 111 PWM with fault.
   localparam logic [2:0] M_OFF = 3'b000, M_SET = 3'b001, M_CLR = 3'b010,
                          M_TGL = 3'b011, M_P1 = 3'b100, M_PN = 3'b101,
                          M_PWM = 3'b110, M_PWMF = 3'b111;

   typedef struct {
      logic  pin;
      logic  oe;
      logic  irq;
      logic  flt;
      string req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] tmr_a, tmr_b;
   logic        per_a, per_b, tb_sel;
   logic        mode_we, pri_we, sec_we;
   logic [2:0]  mode_wdata;
   logic [15:0] pri_wdata, sec_wdata;
   logic        fault_n;
   logic        pin_out, pin_oe, irq_flag, fault_flag;

   int   n_chk  = 0;
   int   n_fail = 0;
   exp_t sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cmp_out_channel dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tmr_a      (tmr_a),
      .tmr_b      (tmr_b),
      .per_a      (per_a),
      .per_b      (per_b),
      .tb_sel     (tb_sel),
      .mode_we    (mode_we),
      .mode_wdata (mode_wdata),
      .pri_we     (pri_we),
      .pri_wdata  (pri_wdata),
      .sec_we     (sec_we),
      .sec_wdata  (sec_wdata),
      .fault_n    (fault_n),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe),
      .irq_flag   (irq_flag),
      .fault_flag (fault_flag)
   );

   // monitor: compares one expected item per clock, just after the edge
   always @(posedge clk) begin
      exp_t e;
      #1;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         n_chk++;
         if (pin_out !== e.pin || pin_oe !== e.oe || irq_flag !== e.irq || fault_flag !== e.flt) begin
            n_fail++;
            $display("FAIL %s at %0t: pin/oe/irq/flt got %b%b%b%b expected %b%b%b%b", e.req, $time,
                     pin_out, pin_oe, irq_flag, fault_flag, e.pin, e.oe, e.irq, e.flt);
         end
      end
   end

   task automatic push(input logic p, input logic o, input logic i, input logic f, input string r);
      exp_t e;
      e.pin = p; e.oe = o; e.irq = i; e.flt = f; e.req = r;
      sb_q.push_back(e);
   endtask

   // one counting cycle, optional secondary write
   task automatic step(input logic [15:0] ca, input logic [15:0] cb, input logic pa, input logic pb,
                       input logic fn, input logic swe, input logic [15:0] sv,
                       input logic ep, input logic eo, input logic ei, input logic ef, input string r);
      @(negedge clk);
      tmr_a = ca; tmr_b = cb; per_a = pa; per_b = pb; fault_n = fn;
      mode_we = 1'b0; pri_we = 1'b0; sec_we = swe; sec_wdata = sv;
      push(ep, eo, ei, ef, r);
   endtask

   // register write cycle: kind 0 = mode, 1 = primary, 2 = secondary
   task automatic wr(input int kind, input logic [15:0] v,
                     input logic ep, input logic eo, input logic ef, input string r);
      @(negedge clk);
      tmr_a = 16'hFFFF; tmr_b = 16'hFFFF; per_a = 1'b0; per_b = 1'b0; fault_n = 1'b1;
      mode_we = (kind == 0); mode_wdata = v[2:0];
      pri_we  = (kind == 1); pri_wdata  = v;
      sec_we  = (kind == 2); sec_wdata  = v;
      push(ep, eo, 1'b0, ef, r);
   endtask

   task automatic setup(input logic [15:0] p, input logic [15:0] s);
      wr(0, 16'(M_OFF), 1'b0, 1'b0, 1'b0, "R2");
      wr(1, p, 1'b0, 1'b0, 1'b0, "R2");
      wr(2, s, 1'b0, 1'b0, 1'b0, "R2");
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; tmr_a = '0; tmr_b = '0; per_a = 0; per_b = 0; tb_sel = 0;
      mode_we = 0; mode_wdata = '0; pri_we = 0; pri_wdata = '0; sec_we = 0; sec_wdata = '0;
      fault_n = 1'b1;
      repeat (3) @(negedge clk);
      n_chk++;
      if (pin_out !== 0 || pin_oe !== 0 || irq_flag !== 0 || fault_flag !== 0) begin
         n_fail++;
         $display("FAIL R1: reset outputs got %b%b%b%b expected 0000", pin_out, pin_oe, irq_flag, fault_flag);
      end
      rst_n = 1'b1;

      // R1 after release, then R2: disabled channel with matching counts
      setup(16'd3, 16'd5);
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'(c), c == 9, c == 9, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");

      // R4 set-high mode
      setup(16'd4, 16'd8);
      wr(0, 16'(M_SET), 1'b0, 1'b1, 1'b0, "R12");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, c >= 4, 1'b1, c == 4, 1'b0, "R4");

      // R4/R5 clear-low mode starts high
      setup(16'd6, 16'd8);
      wr(0, 16'(M_CLR), 1'b1, 1'b1, 1'b0, "R5");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, c < 6, 1'b1, c == 6, 1'b0, "R4");

      // R4 toggle mode, two periods
      setup(16'd2, 16'd8);
      wr(0, 16'(M_TGL), 1'b0, 1'b1, 1'b0, "R5");
      for (int p = 0; p < 2; p++)
         for (int c = 0; c < 10; c++)
            step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0,
                 (p == 0) ? (c >= 2) : (c < 2), 1'b1, c == 2, 1'b0, "R4");

      // R6 single pulse, then silence, then re-arm by rewrite (R5)
      setup(16'd3, 16'd6);
      wr(0, 16'(M_P1), 1'b0, 1'b1, 1'b0, "R5");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, c >= 3 && c < 6, 1'b1, c == 6, 1'b0, "R6");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
      wr(0, 16'(M_P1), 1'b0, 1'b1, 1'b0, "R5");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, c >= 3 && c < 6, 1'b1, c == 6, 1'b0, "R5");

      // R7 continuous pulses on timebase B; timebase A skewed (R3)
      setup(16'd2, 16'd7);
      tb_sel = 1'b1;
      wr(0, 16'(M_PN), 1'b0, 1'b1, 1'b0, "R3");
      for (int p = 0; p < 2; p++)
         for (int c = 0; c < 10; c++)
            step(16'((c + 5) % 10), 16'(c), ((c + 5) % 10) == 9, c == 9, 1'b1, 1'b0, 16'd0,
                 c >= 2 && c < 7, 1'b1, c == 7, 1'b0, "R7");
      tb_sel = 1'b0;

      // R8 PWM, per_b noise (R3), fault pin ignored (R10), buffered duty (R9)
      setup(16'd0, 16'd4);
      wr(0, 16'(M_PWM), 1'b0, 1'b1, 1'b0, "R12");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, c == 4, !(c == 2 || c == 3), 1'b0, 16'd0,
              c == 9, 1'b1, 1'b0, 1'b0, "R10");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, c == 1, 16'd7,
              c < 4 || c == 9, 1'b1, c == 4, 1'b0, "R9");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0,
              c < 7 || c == 9, 1'b1, c == 7, 1'b0, "R8");

      // R11 fault-protected PWM: latch, hold, clear by rewrite
      setup(16'd0, 16'd5);
      wr(0, 16'(M_PWMF), 1'b0, 1'b1, 1'b0, "R12");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, c == 9, 1'b1, 1'b0, 1'b0, "R8");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, c != 2, 1'b0, 16'd0,
              c < 2, c < 2, 1'b0, c >= 2, "R11");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
      wr(0, 16'(M_PWMF), 1'b0, 1'b1, 1'b0, "R5");
      for (int c = 0; c < 10; c++)
         step(16'(c), 16'd0, c == 9, 1'b0, 1'b1, 1'b0, 16'd0, c == 9, 1'b1, 1'b0, 1'b0, "R11");

      wr(0, 16'(M_OFF), 1'b0, 1'b0, 1'b0, "R2");
      @(negedge clk);
      mode_we = 1'b0;
      repeat (3) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule